// File: doc/BRIEF.md
# Transition-Filtered Status Register Group

This block holds one level of an instrument-style status hierarchy. A vector of hardware status lines is sampled into a condition section. Each bit has two filter masks, one for rising edges and one for falling edges, which decide whether a change on that line latches a sticky event bit. An enable mask selects which latched events feed a single summary output. That output is meant to drive one condition bit of a parent group.

A small register bus reads and writes the five sections. The bus uses a select, a write flag and a 3-bit address. Read data is combinational while the select is high. A read of the event section returns the latched events and clears them at the same clock edge. A separate strobe also clears them. Condition bits chosen by a parameter act as summary inputs from a child group. Such a bit holds a captured 1 until the condition section is read.

Top module: `evt_status_group`

## Requirements
- R1: After reset the sections read as follows. Condition, event and enable read 0x0000. Rising filter reads 0x7FFF. Falling filter reads 0x0000. The summary output is 0.
- R2: The condition section (address 0) shows the value of hw_status from the previous clock edge. Writes to address 0 have no effect, and a read does not change an ordinary condition bit.
- R3: A 0-to-1 change on condition bit i sets event bit i on the next edge only if rising-filter bit i (address 1) is 1.
- R4: A 1-to-0 change on condition bit i sets event bit i on the next edge only if falling-filter bit i (address 2) is 1.
- R5: A read of the event section (address 3) returns its contents and clears it. An edge that is pending in that same cycle is still latched.
- R6: A one-cycle pulse on evt_clear empties the event section.
- R7: Event bits are sticky. A set bit stays set when its condition line returns to its old level. It is cleared only by an event read or by evt_clear.
- R8: summary is 1 exactly when some bit is 1 in both the event section and the enable section (address 4).
- R9: Bit 15 reads as 0 from every section, whatever is written or driven.
- R10: A condition bit named in SUM_MASK (default: bit 14) captures a 1 from hw_status and holds it. A read of the condition section clears it, unless hw_status still drives it high.
- R11: Both filter sections and the enable section read back the value last written, with bit 15 forced to 0. Addresses 5 to 7 read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_status | input | 16 | Live hardware status lines |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Section select: 0 cond, 1 rise filter, 2 fall filter, 3 event, 4 enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_sel is high and bus_wr is low |
| evt_clear | input | 1 | Synchronous clear strobe for the event section |
| summary | output | 1 | OR of event AND enable, to the parent group |

## Verification
Most faults in the stored state show up on summary or on an event read within two clock edges of the stimulus: a wrong previous-condition copy, a filter bit stuck at the wrong value, or a lost set during a read-clear. The bench therefore checks the event section exactly two edges after each hw_status change, including an edge that lands in the same cycle as an event read. Faults in the child-summary path only show after a condition read, so that path is checked with back-to-back condition reads.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int SEC_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEC_COND = 3'd0,
    SEC_RISE = 3'd1,
    SEC_FALL = 3'd2,
    SEC_EVT  = 3'd3,
    SEC_EN   = 3'd4
  } sec_e;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/evt_cond_track.sv
module evt_cond_track #(
  parameter int W = 16,
  parameter logic [W-1:0] SUM_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_status,
  input  logic         rd_cond,
  output logic [W-1:0] cond_q,
  output logic [W-1:0] cond_prev,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] cond_d;

  // per-bit next state: plain sample or capture-until-read
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W-1) begin : g_msb
      assign cond_d[i] = 1'b0;
    end else if (SUM_MASK[i]) begin : g_sum
      assign cond_d[i] = hw_status[i] | (cond_q[i] & ~rd_cond);
    end else begin : g_live
      assign cond_d[i] = hw_status[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q    <= '0;
      cond_prev <= '0;
    end else begin
      cond_q    <= cond_d;
      cond_prev <= cond_q;
    end
  end

  assign rise = cond_q & ~cond_prev;
  assign fall = ~cond_q & cond_prev;
endmodule

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] val_q
);
  localparam logic [W-1:0] KEEP = {1'b0, {(W-1){1'b1}}};
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (wr_en) val_d = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RST_VAL & KEEP;
    else        val_q <= val_d;
  end
endmodule

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] evt_d;

  // set wins over clear in the same cycle
  always_comb begin
    evt_d = clr ? '0 : evt_q;
    evt_d = evt_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end
endmodule

// File: rtl/evt_status_group.sv
module evt_status_group
  import evt_status_pkg::*;
#(
  parameter int W = SEC_W,
  parameter logic [W-1:0] SUM_MASK = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      hw_status,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              evt_clear,
  output logic              summary
);
  localparam logic [W-1:0] KEEP     = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] RISE_RST = KEEP;

  logic         rst_sync_n;
  logic         rd_cond, rd_evt, wr_rise, wr_fall, wr_en;
  logic [W-1:0] cond_q, cond_prev, rise, fall;
  logic [W-1:0] rise_q, fall_q, en_q, evt_q, set_vec;

  evt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  always_comb begin
    rd_cond = bus_sel && !bus_wr && (sec_e'(bus_addr) == SEC_COND);
    rd_evt  = bus_sel && !bus_wr && (sec_e'(bus_addr) == SEC_EVT);
    wr_rise = bus_sel &&  bus_wr && (sec_e'(bus_addr) == SEC_RISE);
    wr_fall = bus_sel &&  bus_wr && (sec_e'(bus_addr) == SEC_FALL);
    wr_en   = bus_sel &&  bus_wr && (sec_e'(bus_addr) == SEC_EN);
  end

  evt_cond_track #(.W(W), .SUM_MASK(SUM_MASK)) u_cond (
    .clk(clk), .rst_n(rst_sync_n), .hw_status(hw_status), .rd_cond(rd_cond),
    .cond_q(cond_q), .cond_prev(cond_prev), .rise(rise), .fall(fall)
  );

  evt_cfg_reg #(.W(W), .RST_VAL(RISE_RST)) u_rise (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_rise), .wdata(bus_wdata), .val_q(rise_q)
  );
  evt_cfg_reg #(.W(W), .RST_VAL('0)) u_fall (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_fall), .wdata(bus_wdata), .val_q(fall_q)
  );
  evt_cfg_reg #(.W(W), .RST_VAL('0)) u_en (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wdata(bus_wdata), .val_q(en_q)
  );

  assign set_vec = ((rise & rise_q) | (fall & fall_q)) & KEEP;

  evt_latch #(.W(W)) u_evt (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_vec),
    .clr(rd_evt || evt_clear), .evt_q(evt_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (sec_e'(bus_addr))
        SEC_COND: bus_rdata = cond_q;
        SEC_RISE: bus_rdata = rise_q;
        SEC_FALL: bus_rdata = fall_q;
        SEC_EVT:  bus_rdata = evt_q;
        SEC_EN:   bus_rdata = en_q;
        default:  bus_rdata = '0;
      endcase
    end
    bus_rdata = bus_rdata & KEEP;
  end

  assign summary = |(evt_q & en_q);
endmodule

// File: rtl/evt_status_group_chk.sv
module evt_status_group_chk
  import evt_status_pkg::*;
#(
  parameter int W = SEC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_rdata,
  input logic              evt_clear,
  input logic              summary,
  input logic [W-1:0]      evt_q,
  input logic [W-1:0]      en_q,
  input logic [W-1:0]      rise_q,
  input logic [W-1:0]      cond_q,
  input logic [W-1:0]      cond_prev
);
  logic evt_rd, rise_wr;
  assign evt_rd  = bus_sel && !bus_wr && (bus_addr == SEC_EVT);
  assign rise_wr = bus_sel &&  bus_wr && (bus_addr == SEC_RISE);

  a_r9_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[W-1] == 1'b0);

  a_r8_no_summary_unenabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !summary);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != '0 && !evt_rd && !evt_clear) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && cond_q == cond_prev) |=> (evt_q == '0));

  a_r11_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_wr |=> $stable(rise_q));
endmodule

bind evt_status_group evt_status_group_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .evt_clear(evt_clear),
  .summary(summary), .evt_q(evt_q), .en_q(en_q), .rise_q(rise_q),
  .cond_q(cond_q), .cond_prev(cond_prev)
);

// File: tb/evt_status_group_bench.sv
module evt_status_group_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] hw_status;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        evt_clear, summary;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_status_group u_evt_status_group (
    .clk(clk), .rst_n(rst_n), .hw_status(hw_status), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_clear(evt_clear), .summary(summary)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    tick();
    bus_sel = 0;
  endtask

  task automatic set_hw(input logic [15:0] v);
    hw_status = v; tick(); tick();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(0, d); check("R1 cond", d, 16'h0000);
    rd(1, d); check("R1 rise", d, 16'h7FFF);
    rd(2, d); check("R1 fall", d, 16'h0000);
    rd(3, d); check("R1 event", d, 16'h0000);
    rd(4, d); check("R1 enable", d, 16'h0000);
    check("R1 summary", {15'd0, summary}, 16'h0000);
  endtask

  task automatic t_cond();
    logic [15:0] d;
    set_hw(16'h0A05);
    rd(0, d); check("R2 cond follows", d, 16'h0A05);
    wr(0, 16'h1234);
    rd(0, d); check("R2 write ignored", d, 16'h0A05);
    rd(0, d); check("R2 read keeps", d, 16'h0A05);
    rd(3, d); check("R3 rise all enabled", d, 16'h0A05);
    set_hw(16'h0000);
    rd(3, d); check("R4 fall filter off", d, 16'h0000);
  endtask

  task automatic t_rise();
    logic [15:0] d;
    wr(1, 16'h0001);
    set_hw(16'h0003);
    rd(3, d); check("R3 filtered rise", d, 16'h0001);
    set_hw(16'h0000);
    rd(3, d); check("R3 no event on fall", d, 16'h0000);
  endtask

  task automatic t_fall();
    logic [15:0] d;
    wr(2, 16'h0010);
    set_hw(16'h0030);
    rd(3, d); check("R4 rise blocked", d, 16'h0000);
    set_hw(16'h0000);
    rd(3, d); check("R4 filtered fall", d, 16'h0010);
    wr(2, 16'h0000);
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    wr(1, 16'h0040);
    set_hw(16'h0040);
    set_hw(16'h0000);
    tick(); tick();
    rd(3, d); check("R7 sticky after line drop", d, 16'h0040);
  endtask

  task automatic t_race();
    logic [15:0] d;
    wr(1, 16'h7FFF);
    set_hw(16'h0200);
    hw_status = 16'h0300;
    tick();
    rd(3, d); check("R5 read returns old", d, 16'h0200);
    rd(3, d); check("R5 same-cycle edge kept", d, 16'h0100);
    rd(3, d); check("R5 cleared", d, 16'h0000);
    set_hw(16'h0000);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    set_hw(16'h000C);
    evt_clear = 1; tick(); evt_clear = 0;
    rd(3, d); check("R6 strobe clears", d, 16'h0000);
    set_hw(16'h0000);
  endtask

  task automatic t_summary();
    set_hw(16'h0004);
    check("R8 enable off", {15'd0, summary}, 16'h0000);
    wr(4, 16'h0004);
    check("R8 enabled bit", {15'd0, summary}, 16'h0001);
    wr(4, 16'h0008);
    check("R8 other bit", {15'd0, summary}, 16'h0000);
    wr(4, 16'h0004);
    evt_clear = 1; tick(); evt_clear = 0;
    check("R8 after clear", {15'd0, summary}, 16'h0000);
    wr(4, 16'h0000);
    set_hw(16'h0000);
  endtask

  task automatic t_msb();
    logic [15:0] d;
    wr(1, 16'hFFFF);
    rd(1, d); check("R9 rise msb", d, 16'h7FFF);
    wr(4, 16'hFFFF);
    rd(4, d); check("R11 enable readback", d, 16'h7FFF);
    wr(4, 16'h0000);
    wr(2, 16'h1234);
    rd(2, d); check("R11 fall readback", d, 16'h1234);
    wr(2, 16'h0000);
    set_hw(16'h8000);
    rd(0, d); check("R9 cond msb", d, 16'h0000);
    rd(3, d); check("R9 event msb", d, 16'h0000);
    set_hw(16'h0000);
    rd(5, d); check("R11 addr5", d, 16'h0000);
    rd(7, d); check("R11 addr7", d, 16'h0000);
  endtask

  task automatic t_sumbit();
    logic [15:0] d;
    hw_status = 16'h4001; tick();
    hw_status = 16'h0000; tick(); tick();
    rd(0, d); check("R10 captured", d, 16'h4000);
    rd(0, d); check("R10 cleared by read", d, 16'h0000);
    hw_status = 16'h4000; tick(); tick();
    rd(0, d);
    rd(0, d); check("R10 held while driven", d, 16'h4000);
    set_hw(16'h0000);
    rd(0, d);
    tick();
    rd(3, d);
  endtask

  initial begin
    rst_n = 0; hw_status = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0;
    bus_wdata = 0; evt_clear = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_cond();
    t_rise();
    t_fall();
    t_sticky();
    t_race();
    t_clear();
    t_summary();
    t_msb();
    t_sumbit();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule